// File: doc/BRIEF.md
# Serial Switch-Input Status Port with Change Interrupt

This block watches a bank of switch inputs (16 by default, 8 in the narrow build) and lets a host read their state over a four-wire serial link. When the active-low chip select falls, the block freezes a snapshot of every input. Each rising edge of the serial clock then presents the next snapshot bit on the serial output, starting with the highest-numbered input. The serial input is sampled on each falling edge and travels through the same shift path. After the snapshot bits, the bits taken from the serial input come out in the order they arrived, so several ports can be chained on one select line.

All pins are asynchronous to the block clock. Each pin passes through a two-flop synchroniser, and edges of select and serial clock are found in the clock domain. A sticky pending flag records any difference between the synchronised inputs and the last snapshot. The flag drives an open-drain style interrupt pin, modelled as a drive-low enable, and an enable pin gates that pin without clearing the flag. The serial output is modelled as a value plus an output enable.

The transfer controller has three states. ST_IDLE means deselected, with the output in high impedance. On a select falling edge the controller takes the snapshot and moves to ST_ARMED, which drives the snapshot MSB and waits for the first serial clock rise. That rise moves it to ST_SHIFT, where falling edges shift the register. A high select returns ST_ARMED or ST_SHIFT to ST_IDLE at any point.

Top module: `spi_switch_monitor`

## Requirements
- R1: After reset sdout_oe is 0, int_drive_low is 0, and the stored snapshot is all zero.
- R2: Three clock cycles after cs_n falls, the synchronised inputs are stored as the snapshot, sdout_oe goes to 1, and sdout already carries snapshot bit NUM_INPUTS-1.
- R3: The k-th SCLK rising edge of a transfer (k = 1..NUM_INPUTS) presents snapshot bit NUM_INPUTS-k on sdout, so bits go out from the top input down to input 0.
- R4: sdin is sampled on each SCLK falling edge. From rising edge NUM_INPUTS+1 onward, sdout repeats the sampled sdin bits in the order they were received.
- R5: sdout_oe is 1 only while selected and returns to 0 within three clock cycles of cs_n going high, including when a transfer is cut short.
- R6: Any difference between the synchronised inputs and the snapshot sets the pending interrupt within three cycles. The flag stays set even if the input returns to its snapshot value.
- R7: The select falling edge that takes a snapshot clears the pending interrupt. Any input change after that capture raises it again.
- R8: int_drive_low equals pending AND int_en with no clock delay. Holding int_en at 0 does not clear the pending flag.
- R9: Input changes during a transfer do not alter the bits shifted out in that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_in | input | NUM_INPUTS | Switch inputs, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in (chain input) |
| int_en | input | 1 | 1 lets the interrupt pin pull low |
| sdout | output | 1 | Serial data out value |
| sdout_oe | output | 1 | 1 drives sdout, 0 means high impedance |
| int_drive_low | output | 1 | 1 pulls the interrupt line low |

## Verification
Every pin passes two synchroniser flops and one registered stage, so each result lands three clock edges after its cause. This covers the snapshot and output enable after a select fall, the new sdout bit after an SCLK rise, the pending flag after an input change, and the return to high impedance after select rises. The only exception is int_en, which acts on int_drive_low at once. The bench drives pins on falling clock edges and samples four to six cycles after each stimulus, still inside the same serial-clock phase. A driver task queues the expected bit for each rising edge, and a monitor compares it against sdout at the end of that high phase.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SHIFT = 2'd2
    } xfer_state_e;

endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int              WIDTH     = 1,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
        end
    end

    assign q = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/gpi_xfer_fsm.sv
module gpi_xfer_fsm
    import gpi_pkg::*;
#(
    parameter int NUM_INPUTS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_s,
    input  logic                  sclk_s,
    input  logic                  sdin_s,
    input  logic [NUM_INPUTS-1:0] in_s,
    output logic                  capture,
    output logic                  sdout,
    output logic                  sdout_oe
);
    localparam int MSB = NUM_INPUTS - 1;

    xfer_state_e state_q, state_d;
    logic        cs_d, sclk_d;
    logic        cs_fall, sclk_rise, sclk_fall;
    logic [MSB:0] shreg_q;
    logic        sdout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_d   <= cs_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = cs_d & ~cs_s;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cs_s)           state_d = ST_IDLE;
                else if (sclk_rise) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign capture = (state_q == ST_IDLE) && cs_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            sdout_q <= 1'b0;
        end else if (capture) begin
            shreg_q <= in_s;
            sdout_q <= in_s[MSB];
        end else if (state_q != ST_IDLE && !cs_s) begin
            if (sclk_rise) begin
                sdout_q <= shreg_q[MSB];
            end
            if (state_q == ST_SHIFT && sclk_fall) begin
                shreg_q <= {shreg_q[MSB-1:0], sdin_s};
            end
        end
    end

    assign sdout    = sdout_q;
    assign sdout_oe = (state_q != ST_IDLE);

endmodule

// File: rtl/gpi_change_det.sv
module gpi_change_det #(
    parameter int NUM_INPUTS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [NUM_INPUTS-1:0] in_s,
    output logic                  int_pend
);
    logic [NUM_INPUTS-1:0] snap_q;
    logic [NUM_INPUTS-1:0] diff;
    logic                  pend_q;

    generate
        for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_diff
            assign diff[i] = in_s[i] ^ snap_q[i];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            pend_q <= 1'b0;
        end else if (capture) begin
            snap_q <= in_s;
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_q | (|diff);
        end
    end

    assign int_pend = pend_q;

endmodule

// File: rtl/spi_switch_monitor.sv
module spi_switch_monitor #(
    parameter int NUM_INPUTS  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_INPUTS-1:0] sw_in,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdin,
    input  logic                  int_en,
    output logic                  sdout,
    output logic                  sdout_oe,
    output logic                  int_drive_low
);
    localparam int CTRL_W = 3;

    logic [NUM_INPUTS-1:0] in_s;
    logic [CTRL_W-1:0]     ctrl_s;
    logic                  capture;
    logic                  int_pend;

    gpi_sync #(
        .WIDTH     (NUM_INPUTS),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ('0)
    ) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sw_in),
        .q     (in_s)
    );

    gpi_sync #(
        .WIDTH     (CTRL_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_ctrl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdin}),
        .q     (ctrl_s)
    );

    gpi_xfer_fsm #(
        .NUM_INPUTS (NUM_INPUTS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (ctrl_s[2]),
        .sclk_s   (ctrl_s[1]),
        .sdin_s   (ctrl_s[0]),
        .in_s     (in_s),
        .capture  (capture),
        .sdout    (sdout),
        .sdout_oe (sdout_oe)
    );

    gpi_change_det #(
        .NUM_INPUTS (NUM_INPUTS)
    ) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .in_s     (in_s),
        .int_pend (int_pend)
    );

    assign int_drive_low = int_pend & int_en;

endmodule

// File: rtl/spi_switch_monitor_chk.sv
module spi_switch_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic int_en,
    input logic sdout,
    input logic sdout_oe,
    input logic int_drive_low
);
    // R5: select held high long enough leaves the output undriven
    p_hiz_when_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdout_oe);

    // R8: disabled interrupt pin never pulls low
    p_int_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !int_drive_low);

    // R7: the capture that enables the output also clears the interrupt
    p_capture_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdout_oe) |-> !int_drive_low);

    // R6: with the pin enabled, an interrupt holds until the next capture
    p_int_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(int_drive_low) && int_en && $past(int_en) && !$rose(sdout_oe))
        |-> int_drive_low);

    // R3: sdout only moves after a serial clock rise
    p_sdout_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sdout_oe && $past(sdout_oe) && ($past(sclk, 3) == $past(sclk, 4)))
        |-> $stable(sdout));

endmodule

bind spi_switch_monitor spi_switch_monitor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .sclk          (sclk),
    .int_en        (int_en),
    .sdout         (sdout),
    .sdout_oe      (sdout_oe),
    .int_drive_low (int_drive_low)
);

// File: tb/spi_switch_monitor_test.sv
module spi_switch_monitor_test;
    localparam int W    = 16;
    localparam int HALF = 6;

    typedef struct {
        logic  val;
        string req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] sw_in = '0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdin = 1'b0;
    logic         int_en = 1'b1;
    logic         sdout, sdout_oe, int_drive_low;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t exp_q[$];
    event smp;

    always #2 clk = ~clk;

    spi_switch_monitor #(.NUM_INPUTS(W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_in         (sw_in),
        .cs_n          (cs_n),
        .sclk          (sclk),
        .sdin          (sdin),
        .int_en        (int_en),
        .sdout         (sdout),
        .sdout_oe      (sdout_oe),
        .int_drive_low (int_drive_low)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops one expected sdout bit per sample request
    initial begin
        forever begin
            @(smp);
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard: actual %b expected none", sdout);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (sdout !== e.val || sdout_oe !== 1'b1) begin
                    fails++;
                    $display("FAIL %s: actual %b/oe%b expected %b/oe1 at %0t",
                             e.req, sdout, sdout_oe, e.val, $time);
                end
            end
        end
    end

    // driver: one full transfer; chg_at > 0 changes the inputs at that rise
    task automatic xfer(input logic [W-1:0] snap, input int nextra,
                        input logic [31:0] din, input int chg_at,
                        input logic [W-1:0] chg_val);
        int   total;
        exp_t e;
        total = W + nextra;
        cs_n = 1'b0;
        tick(4);
        chk(sdout_oe, 1, "R5");
        chk(int_drive_low, 0, "R7");
        e.val = snap[W-1]; e.req = "R2";
        exp_q.push_back(e);
        ->smp;
        for (int k = 1; k <= total; k++) begin
            sclk = 1'b1;
            sdin = (k <= nextra) ? din[k-1] : 1'b0;
            if (k == chg_at) sw_in = chg_val;
            if (k <= W) begin
                e.val = snap[W-k];
                e.req = (chg_at > 0) ? "R9" : "R3";
            end else begin
                e.val = din[k-W-1];
                e.req = "R4";
            end
            exp_q.push_back(e);
            tick(HALF);
            ->smp;
            sclk = 1'b0;
            tick(HALF);
        end
        cs_n = 1'b1;
        sdin = 1'b0;
        tick(4);
        chk(sdout_oe, 0, "R5");
        chk(exp_q.size(), 0, "scoreboard drain");
    endtask

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(6);
        chk(sdout_oe, 0, "R1");
        chk(int_drive_low, 0, "R1");

        // any input differing from the all-zero snapshot raises the interrupt
        sw_in = 16'hA5C3;
        tick(5);
        chk(int_drive_low, 1, "R6");

        // enable pin gates immediately and keeps the pending flag
        int_en = 1'b0;
        #1;
        chk(int_drive_low, 0, "R8");
        tick(3);
        int_en = 1'b1;
        #1;
        chk(int_drive_low, 1, "R8");
        tick(1);

        // read snapshot then eight chained bits
        xfer(16'hA5C3, 8, 32'h0000_004D, 0, '0);
        chk(int_drive_low, 0, "R7");

        // glitch that returns to the snapshot value stays latched
        sw_in = 16'hA5C2;
        tick(5);
        sw_in = 16'hA5C3;
        tick(5);
        chk(int_drive_low, 1, "R6");

        // inputs change mid-transfer: shifted data keeps the old snapshot
        xfer(16'hA5C3, 4, 32'h0000_0006, 3, 16'h0F0F);
        chk(int_drive_low, 1, "R7");

        // quiet inputs: capture clears and nothing re-raises
        xfer(16'h0F0F, 2, 32'h0000_0001, 0, '0);
        chk(int_drive_low, 0, "R7");

        // aborted transfer returns the output to high impedance
        cs_n = 1'b0;
        tick(4);
        chk(sdout_oe, 1, "R5");
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b1; tick(HALF);
            sclk = 1'b0; tick(HALF);
        end
        cs_n = 1'b1;
        tick(4);
        chk(sdout_oe, 0, "R5");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule